// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns one of several reference enable pulses, all in the system clock domain, into a one-cycle sample strobe for the audio path. A two-bit source code picks the reference. Each reference pulse is one count for a divider.

In programmable mode the divider ratio is a fixed base factor of 256 times (N + 1), where N is a 4-bit prescale. The internal references and the external reference each have their own prescale register. When the selected prescale is zero, the block switches to a legacy-compatible path. There a separate two-bit rate code chooses one of three fixed ratios, or mutes the strobe entirely.

Two flags report the configuration. One shows that the legacy path is active. The other shows that the settings are unusable for the converter, either through an unsupported prescale or an undefined source.

Top module: `srgen_top`

## Requirements
- R1: After synchronous reset the internal prescale is 1, the external prescale is 0, the source code is 00 and the legacy code is 00. The outputs `sample_stb`, `legacy_mode` and `cfg_invalid` are all low.
- R2: Source code 00 counts `ref_int25_en`, 01 counts `ref_ext_en` and 10 counts `ref_int32_en`. Pulses on the two unselected reference inputs have no effect on the strobe.
- R3: In programmable mode `sample_stb` is high for exactly one cycle, in the cycle after every BASE_DIV×(N+1)-th counted reference pulse.
- R4: Only bits 3:0 of a prescale write are stored. For example, writing 0x23 acts as N = 3, and writing 0xF0 acts as N = 0.
- R5: Source codes 00 and 10 use the internal prescale (address 0). Source code 01 uses the external prescale (address 1).
- R6: When the selected prescale is 0, `legacy_mode` is 1 and the ratio is set by the legacy code. Code 11 gives LEG_DIV, code 10 gives 2×LEG_DIV and code 01 gives 4×LEG_DIV counted pulses per strobe.
- R7: In legacy mode, legacy code 00 produces no strobe.
- R8: Source code 11 produces no strobe and drives `cfg_invalid` high.
- R9: In programmable mode `cfg_invalid` is 1 for N in {6, 8, 10, 12, 13, 14, 15} and 0 for N in {1, 2, 3, 4, 5, 7, 9, 11}. In legacy mode it is 0 unless the source code is 11.
- R10: Any register write clears the divider count to zero. No strobe appears in the cycle after a write.
- R11: Register addresses are as follows. Address 0 is the internal prescale, 1 the external prescale, 2 the source code in bits 1:0, and 3 the legacy code in bits 1:0. Upper data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| ref_int25_en | input | 1 | Enable pulse of the first internal reference |
| ref_ext_en | input | 1 | Enable pulse of the external reference |
| ref_int32_en | input | 1 | Enable pulse of the second internal reference |
| sample_stb | output | 1 | One-cycle sample-rate strobe |
| legacy_mode | output | 1 | Legacy rate path active |
| cfg_invalid | output | 1 | Prescale or source unusable for the converter |

## Verification
If the divider count goes wrong, `sample_stb` moves away from its expected cycle. The bench compares the strobe on every cycle, so the error shows at the very next strobe, at most BASE_DIV×16 counted pulses later. A wrong register value or a wrong prescale choice shows up at once in `legacy_mode` or `cfg_invalid`, and in the strobe period from the following strobe onward. A reload that a write failed to perform makes the first strobe after that write arrive early.

// File: rtl/srgen_pkg.sv
package srgen_pkg;

    localparam int PRE_W = 4;

    typedef enum logic [1:0] {
        SRC_INT25 = 2'b00,
        SRC_EXT   = 2'b01,
        SRC_INT32 = 2'b10,
        SRC_NONE  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        LEG_MUTE = 2'b00,
        LEG_LOW  = 2'b01,
        LEG_MID  = 2'b10,
        LEG_HIGH = 2'b11
    } leg_e;

    typedef enum logic [1:0] {
        A_INT_PRE = 2'd0,
        A_EXT_PRE = 2'd1,
        A_SRC     = 2'd2,
        A_LEG     = 2'd3
    } addr_e;

    typedef struct packed {
        logic [PRE_W-1:0] int_pre;
        logic [PRE_W-1:0] ext_pre;
        src_e             src;
        leg_e             leg;
    } cfg_t;

    // prescale values the converter cannot use
    function automatic logic codec_bad(input logic [PRE_W-1:0] n);
        case (n)
            4'd6, 4'd8, 4'd10, 4'd12, 4'd13, 4'd14, 4'd15: codec_bad = 1'b1;
            default:                                      codec_bad = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/srgen_cfg.sv
module srgen_cfg
    import srgen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.int_pre <= PRE_W'(1);
            cfg.ext_pre <= '0;
            cfg.src     <= SRC_INT25;
            cfg.leg     <= LEG_MUTE;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                A_INT_PRE: cfg.int_pre <= wr_data[PRE_W-1:0];
                A_EXT_PRE: cfg.ext_pre <= wr_data[PRE_W-1:0];
                A_SRC:     cfg.src     <= src_e'(wr_data[1:0]);
                default:   cfg.leg     <= leg_e'(wr_data[1:0]);
            endcase
        end
    end

endmodule

// File: rtl/srgen_select.sv
module srgen_select
    import srgen_pkg::*;
#(
    parameter int BASE_DIV = 256,
    parameter int LEG_DIV  = 512,
    parameter int CW       = 13
) (
    input  cfg_t          cfg,
    input  logic          ref_int25_en,
    input  logic          ref_ext_en,
    input  logic          ref_int32_en,
    output logic          tick,
    output logic [CW-1:0] ratio,
    output logic          legacy,
    output logic          invalid
);

    logic [PRE_W-1:0] n_sel;
    logic             ref_sel;
    logic             off;

    always_comb begin
        n_sel  = (cfg.src == SRC_EXT) ? cfg.ext_pre : cfg.int_pre;
        legacy = (n_sel == '0);

        case (cfg.src)
            SRC_INT25: ref_sel = ref_int25_en;
            SRC_EXT:   ref_sel = ref_ext_en;
            SRC_INT32: ref_sel = ref_int32_en;
            default:   ref_sel = 1'b0;
        endcase

        if (legacy)
            ratio = CW'(LEG_DIV) << (2'd3 - 2'(cfg.leg));
        else
            ratio = CW'(BASE_DIV * (int'(n_sel) + 1));

        off     = (cfg.src == SRC_NONE) || (legacy && cfg.leg == LEG_MUTE);
        tick    = ref_sel && !off;
        invalid = (cfg.src == SRC_NONE) || (!legacy && codec_bad(n_sel));
    end

endmodule

// File: rtl/srgen_div.sv
module srgen_div #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] ratio,
    output logic          stb
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            stb <= 1'b0;
        end else if (tick) begin
            if (cnt == ratio - CW'(1)) begin
                cnt <= '0;
                stb <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
                stb <= 1'b0;
            end
        end else begin
            stb <= 1'b0;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < ratio); // R3
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!stb && cnt == '0)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !stb); // R7

endmodule

// File: rtl/srgen_top.sv
module srgen_top
    import srgen_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BASE_DIV = 256,
    parameter int LEG_DIV  = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ref_int25_en,
    input  logic          ref_ext_en,
    input  logic          ref_int32_en,
    output logic          sample_stb,
    output logic          legacy_mode,
    output logic          cfg_invalid
);

    localparam int MAX_PROG = BASE_DIV * (1 << PRE_W);
    localparam int MAX_LEG  = LEG_DIV * 8;
    localparam int MAX_R    = (MAX_PROG > MAX_LEG) ? MAX_PROG : MAX_LEG;
    localparam int CW       = $clog2(MAX_R + 1);

    cfg_t          cfg;
    logic          tick;
    logic [CW-1:0] ratio;

    srgen_cfg #(.DW(DW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    srgen_select #(.BASE_DIV(BASE_DIV), .LEG_DIV(LEG_DIV), .CW(CW)) u_sel (
        .cfg          (cfg),
        .ref_int25_en (ref_int25_en),
        .ref_ext_en   (ref_ext_en),
        .ref_int32_en (ref_int32_en),
        .tick         (tick),
        .ratio        (ratio),
        .legacy       (legacy_mode),
        .invalid      (cfg_invalid)
    );

    srgen_div #(.CW(CW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_en),
        .tick  (tick),
        .ratio (ratio),
        .stb   (sample_stb)
    );

    AST_NO_SOURCE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_NONE) |=> !sample_stb); // R8
    AST_WRITE_NO_STB: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !sample_stb); // R10

endmodule

// File: tb/sim_srgen_top.sv
module sim_srgen_top;

    localparam int BASE = 4;
    localparam int LEG  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       r25 = 1'b0, rext = 1'b0, r32 = 1'b0;
    logic       sample_stb, legacy_mode, cfg_invalid;

    always #4 clk = ~clk; // 125 MHz

    srgen_top #(.DW(8), .BASE_DIV(BASE), .LEG_DIV(LEG)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_int25_en(r25), .ref_ext_en(rext), .ref_int32_en(r32),
        .sample_stb(sample_stb), .legacy_mode(legacy_mode), .cfg_invalid(cfg_invalid)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;
    int    pattern = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_int, m_ext, m_src, m_leg, m_cnt;
    bit m_stb;

    function automatic int sel_n();
        return (m_src == 1) ? m_ext : m_int;
    endfunction

    function automatic bit bad_n(int n);
        return (n == 6 || n == 8 || n == 10 || n >= 12);
    endfunction

    function automatic bit exp_leg();
        return sel_n() == 0;
    endfunction

    function automatic bit exp_inv();
        if (m_src == 3) return 1;
        if (sel_n() == 0) return 0;
        return bad_n(sel_n());
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_int = 1; m_ext = 0; m_src = 0; m_leg = 0; m_cnt = 0; m_stb = 0;
        end else begin
            int n, ratio;
            bit active, pulse;
            n = sel_n();
            if (n == 0) ratio = LEG * (1 << (3 - m_leg));
            else        ratio = BASE * (n + 1);
            active = (m_src != 3) && !(n == 0 && m_leg == 0);
            case (m_src)
                0: pulse = r25;
                1: pulse = rext;
                2: pulse = r32;
                default: pulse = 0;
            endcase
            m_stb = 0;
            if (wr_en) begin
                m_cnt = 0;
                case (wr_addr)
                    2'd0: m_int = wr_data % 16;
                    2'd1: m_ext = wr_data % 16;
                    2'd2: m_src = wr_data % 4;
                    default: m_leg = wr_data % 4;
                endcase
            end else if (active && pulse) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == ratio) begin
                    m_cnt = 0;
                    m_stb = 1;
                end
            end
        end
    end

    task automatic check1(input string t, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", t, what, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check1(tag, "sample_stb", sample_stb, m_stb);
            check1(tag, "legacy_mode", legacy_mode, exp_leg());
            check1(tag, "cfg_invalid", cfg_invalid, exp_inv());
        end
    end

    // reference pulse generation
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (pattern)
            0: begin r25 <= 1'b1; rext <= 1'b1; r32 <= 1'b1; end
            1: begin r25 <= lfsr[0]; rext <= lfsr[5]; r32 <= lfsr[9]; end
            default: begin r25 <= 1'b0; rext <= 1'b0; r32 <= 1'b0; end
        endcase
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_flags(input string t, input logic l, input logic i);
        #1;
        check1(t, "legacy_mode(flag)", legacy_mode, l);
        check1(t, "cfg_invalid(flag)", cfg_invalid, i);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pattern = 2;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check1("R1", "sample_stb(reset)", sample_stb, 1'b0);
        check1("R1", "legacy_mode(reset)", legacy_mode, 1'b0);
        check1("R1", "cfg_invalid(reset)", cfg_invalid, 1'b0);
        rst = 1'b0;
        run(5);
        tag = "R3"; pattern = 0; run(40);
        tag = "R2"; pattern = 1; run(80);
        tag = "R4"; wr(2'd1, 8'h23); wr(2'd2, 8'h01);
        chk_flags("R4", 1'b0, 1'b0); run(100);
        tag = "R5"; wr(2'd0, 8'h02); run(80);
        wr(2'd2, 8'h02); pattern = 0; run(40);
        tag = "R10";
        for (int k = 0; k < 6; k++) begin run(5); wr(2'd2, 8'h02); end
        run(20);
        tag = "R6"; wr(2'd0, 8'h00); chk_flags("R6", 1'b1, 1'b0);
        wr(2'd3, 8'h03); run(40);
        pattern = 1; wr(2'd3, 8'h02); run(80);
        pattern = 0; wr(2'd3, 8'h01); run(80);
        tag = "R7"; wr(2'd3, 8'h00); chk_flags("R7", 1'b1, 1'b0); run(80);
        tag = "R8"; wr(2'd3, 8'h03); wr(2'd2, 8'h03);
        chk_flags("R8", 1'b1, 1'b1); run(60);
        tag = "R9"; wr(2'd2, 8'h00);
        for (int n = 1; n < 16; n++) begin
            wr(2'd0, 8'(n));
            chk_flags("R9", 1'b0, bad_n(n));
            run(2 * BASE * (n + 1) + 3);
        end
        tag = "R11"; wr(2'd0, 8'hF0); chk_flags("R11", 1'b1, 1'b0);
        wr(2'd2, 8'hFE); wr(2'd3, 8'hFF); run(40);
        wr(2'd1, 8'hA0); wr(2'd2, 8'h01); run(40);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule